// File: doc/BRIEF.md
# DDR SDRAM Burst Read Sequencer

This block sits on the controller side of a double-data-rate SDRAM. It takes one read request, which names a bank, a row and a column, together with a burst setting (burst length and sequential or interleaved word order). It opens the row with an activate command. It waits the activate-to-read delay and then issues the read command. After the CAS latency it gathers the returned words. The memory launches two words per clock, one on each edge of the data strobe. The block catches each word with the matching strobe edge and hands both words of a clock to the clock domain as one pair. Each word carries the column address that the burst order assigns to it.

On every cycle with no command to send, the command pins carry a no-operation code. A `busy` flag covers the whole transaction. A one-cycle `done` pulse marks its end. Requests that arrive while the block is busy are dropped.

Top module: `ddr_burst_reader`

## Requirements
- R1: A synchronous active-high reset leaves the block idle. After a clock edge that samples `rst` high, `busy`, `done` and `cap_valid` are 0 and the command pins show the no-operation code.
- R2: No-operation is chip-select low with RAS, CAS and WE all high. The pins show it on every cycle that carries no activate and no read.
- R3: An accepted request is followed, on the next cycle, by one activate cycle: chip-select low, RAS low, CAS high, WE high, with the bank on `sdram_ba` and the row on `sdram_addr`.
- R4: Read is chip-select low and CAS low with RAS and WE high, with the bank on `sdram_ba` and the zero-extended start column on `sdram_addr`. It appears exactly `T_RCD` cycles after the activate cycle.
- R5: `cfg_blen` selects the burst length: 2'b11 gives 8 words, 2'b10 gives 4 words, and 2'b01 or 2'b00 gives 2 words. The block presents length/2 pairs.
- R6: `cap_valid` first rises `CAS_LAT`+1 cycles after the clock edge that samples the read command. It stays high for one cycle per pair, on consecutive cycles.
- R7: In each pair, `cap_data0` is the word present at the rising strobe edge and `cap_data1` is the word present at the following falling strobe edge.
- R8: In sequential order, word i of a burst of length L has column {start[high bits], (start mod L + i) mod L}. The bits above log2(L) are kept.
- R9: In interleaved order, word i has the start column with its low log2(L) bits XORed with i.
- R10: `busy` is high from the cycle after acceptance until the last pair has been presented. In the next cycle `done` is high for exactly one cycle and `busy` is low.
- R11: A request that arrives while `busy` is high produces no further activate, neither during the transaction nor after it.
- R12: The address and burst setting are taken when the request is accepted. Changes to them while `busy` is high leave the running burst unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Read request strobe |
| req_bank | input | BA_W | Bank to read |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | Start column of the burst |
| cfg_interleave | input | 1 | 1 = interleaved order, 0 = sequential order |
| cfg_blen | input | 2 | Burst length code (see R5) |
| sdram_cs_n | output | 1 | Chip select, active low |
| sdram_ras_n | output | 1 | Row strobe, active low |
| sdram_cas_n | output | 1 | Column strobe, active low |
| sdram_we_n | output | 1 | Write enable, active low |
| sdram_ba | output | BA_W | Bank address |
| sdram_addr | output | max(ROW_W,COL_W) | Row or column address |
| dq | input | DQ_W | Read data from memory |
| dqs | input | 1 | Read data strobe |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-burst pulse |
| cap_valid | output | 1 | A captured pair is present |
| cap_data0 | output | DQ_W | Word captured on the rising strobe edge |
| cap_data1 | output | DQ_W | Word captured on the falling strobe edge |
| cap_col0 | output | COL_W | Column of cap_data0 |
| cap_col1 | output | COL_W | Column of cap_data1 |

## Verification
The bench chooses start columns near the top of a burst block, so that the sequential order has to wrap. A sequencer that carries into the upper column bits would report columns outside the block and return the wrong data. Interleaved runs with odd start offsets expose an adder used where an XOR belongs. Burst code 2'b00 and length 8 with start column 0xFF cover the smallest and the largest pair counts. A counter off by one would move the read command or the first pair by a cycle. A late drop of `busy` would let a request that is held high across the end of the transaction start a second activate. A reset in the middle of a burst has to silence the capture outputs at once.

// File: rtl/ddrrd_pkg.sv
package ddrrd_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_ACT  = 2'd1,
        CMD_READ = 2'd2
    } cmd_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pins_t;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_TRCD = 3'd1,
        ST_CL   = 3'd2,
        ST_DATA = 3'd3,
        ST_FIN  = 3'd4
    } state_e;

    // log2 of the burst length for a configuration code
    function automatic logic [1:0] blen_log2(input logic [1:0] code);
        case (code)
            2'b11:   return 2'd3;
            2'b10:   return 2'd2;
            default: return 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/ddrrd_cmd_enc.sv
module ddrrd_cmd_enc
    import ddrrd_pkg::*;
(
    input  cmd_e  cmd,
    output pins_t pins
);
    always_comb begin
        case (cmd)
            CMD_ACT:  pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
            CMD_READ: pins = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
            default:  pins = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
    end
endmodule

// File: rtl/ddrrd_col_order.sv
module ddrrd_col_order #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] start,
    input  logic [2:0]       idx,
    input  logic             interleave,
    input  logic [1:0]       lg,
    output logic [COL_W-1:0] col
);
    logic [2:0] mask;
    logic [2:0] low;
    logic [2:0] offs;

    always_comb begin
        case (lg)
            2'd3:    mask = 3'b111;
            2'd2:    mask = 3'b011;
            default: mask = 3'b001;
        endcase
        low  = start[2:0];
        offs = interleave ? (low ^ idx) : (low + idx);
        col  = {start[COL_W-1:3], (low & ~mask) | (offs & mask)};
    end
endmodule

// File: rtl/ddrrd_dqs_capture.sv
module ddrrd_dqs_capture #(
    parameter int DQ_W = 16
) (
    input  logic            dqs,
    input  logic [DQ_W-1:0] dq,
    output logic [DQ_W-1:0] rise_word,
    output logic [DQ_W-1:0] fall_word
);
    logic [DQ_W-1:0] rise_q;
    logic [DQ_W-1:0] fall_q;

    always_ff @(posedge dqs) rise_q <= dq;
    always_ff @(negedge dqs) fall_q <= dq;

    assign rise_word = rise_q;
    assign fall_word = fall_q;
endmodule

// File: rtl/ddr_burst_reader.sv
module ddr_burst_reader
    import ddrrd_pkg::*;
#(
    parameter int BA_W    = 2,
    parameter int ROW_W   = 12,
    parameter int COL_W   = 8,
    parameter int DQ_W    = 16,
    parameter int T_RCD   = 3,
    parameter int CAS_LAT = 3
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 req_valid,
    input  logic [BA_W-1:0]                      req_bank,
    input  logic [ROW_W-1:0]                     req_row,
    input  logic [COL_W-1:0]                     req_col,
    input  logic                                 cfg_interleave,
    input  logic [1:0]                           cfg_blen,
    output logic                                 sdram_cs_n,
    output logic                                 sdram_ras_n,
    output logic                                 sdram_cas_n,
    output logic                                 sdram_we_n,
    output logic [BA_W-1:0]                      sdram_ba,
    output logic [(ROW_W>COL_W?ROW_W:COL_W)-1:0] sdram_addr,
    input  logic [DQ_W-1:0]                      dq,
    input  logic                                 dqs,
    output logic                                 busy,
    output logic                                 done,
    output logic                                 cap_valid,
    output logic [DQ_W-1:0]                      cap_data0,
    output logic [DQ_W-1:0]                      cap_data1,
    output logic [COL_W-1:0]                     cap_col0,
    output logic [COL_W-1:0]                     cap_col1
);
    localparam int ADDR_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int CNT_MAX = (T_RCD > CAS_LAT) ? T_RCD : CAS_LAT;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        state_e             st;
        logic [CNT_W-1:0]   cnt;
        logic [BA_W-1:0]    ba;
        logic [COL_W-1:0]   col;
        logic               ilv;
        logic [1:0]         lg;
        logic [1:0]         pair;
        cmd_e               cmd;
        logic [ADDR_W-1:0]  addr;
        logic               cap_v;
        logic [DQ_W-1:0]    d0;
        logic [DQ_W-1:0]    d1;
        logic [COL_W-1:0]   c0;
        logic [COL_W-1:0]   c1;
        logic               done;
    } regs_t;

    regs_t r_d, r_q;

    // strobe-edge capture
    logic [DQ_W-1:0] rise_word, fall_word;
    ddrrd_dqs_capture #(.DQ_W(DQ_W)) u_cap (
        .dqs       (dqs),
        .dq        (dq),
        .rise_word (rise_word),
        .fall_word (fall_word)
    );

    // column of each lane for the pair now being collected
    logic [COL_W-1:0] lane_col [2];
    for (genvar l = 0; l < 2; l++) begin : g_lane
        ddrrd_col_order #(.COL_W(COL_W)) u_ord (
            .start      (r_q.col),
            .idx        ({r_q.pair, 1'(l)}),
            .interleave (r_q.ilv),
            .lg         (r_q.lg),
            .col        (lane_col[l])
        );
    end

    logic [1:0] last_pair;
    always_comb begin
        case (r_q.lg)
            2'd3:    last_pair = 2'd3;
            2'd2:    last_pair = 2'd1;
            default: last_pair = 2'd0;
        endcase
    end

    always_comb begin
        r_d       = r_q;
        r_d.cmd   = CMD_NOP;
        r_d.addr  = '0;
        r_d.cap_v = 1'b0;
        r_d.done  = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st   = ST_TRCD;
                    r_d.cmd  = CMD_ACT;
                    r_d.ba   = req_bank;
                    r_d.addr = ADDR_W'(req_row);
                    r_d.col  = req_col;
                    r_d.ilv  = cfg_interleave;
                    r_d.lg   = blen_log2(cfg_blen);
                    r_d.pair = 2'd0;
                    r_d.cnt  = CNT_W'(T_RCD - 1);
                end
            end
            ST_TRCD: begin
                if (r_q.cnt == '0) begin
                    r_d.st   = ST_CL;
                    r_d.cmd  = CMD_READ;
                    r_d.addr = ADDR_W'(r_q.col);
                    r_d.cnt  = CNT_W'(CAS_LAT);
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            ST_CL: begin
                if (r_q.cnt == '0) r_d.st = ST_DATA;
                else               r_d.cnt = r_q.cnt - CNT_W'(1);
            end
            ST_DATA: begin
                r_d.cap_v = 1'b1;
                r_d.d0    = rise_word;
                r_d.d1    = fall_word;
                r_d.c0    = lane_col[0];
                r_d.c1    = lane_col[1];
                r_d.pair  = r_q.pair + 2'd1;
                if (r_q.pair == last_pair) r_d.st = ST_FIN;
            end
            ST_FIN: begin
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    pins_t pins;
    ddrrd_cmd_enc u_enc (
        .cmd  (r_q.cmd),
        .pins (pins)
    );

    assign sdram_cs_n  = pins.cs_n;
    assign sdram_ras_n = pins.ras_n;
    assign sdram_cas_n = pins.cas_n;
    assign sdram_we_n  = pins.we_n;
    assign sdram_ba    = r_q.ba;
    assign sdram_addr  = r_q.addr;
    assign busy        = (r_q.st != ST_IDLE);
    assign done        = r_q.done;
    assign cap_valid   = r_q.cap_v;
    assign cap_data0   = r_q.d0;
    assign cap_data1   = r_q.d1;
    assign cap_col0    = r_q.c0;
    assign cap_col1    = r_q.c1;

    // ---------------- checks ----------------
    logic pin_act, pin_read, pin_nop;
    assign pin_act  = !sdram_cs_n && !sdram_ras_n &&  sdram_cas_n &&  sdram_we_n;
    assign pin_read = !sdram_cs_n &&  sdram_ras_n && !sdram_cas_n &&  sdram_we_n;
    assign pin_nop  = !sdram_cs_n &&  sdram_ras_n &&  sdram_cas_n &&  sdram_we_n;

    // cycles elapsed since the last activate seen on the pins
    logic [CNT_W:0] gap_q;
    always_ff @(posedge clk) begin
        if (rst)                   gap_q <= '0;
        else if (pin_act)          gap_q <= (CNT_W+1)'(1);
        else if (gap_q != '0 && gap_q != '1) gap_q <= gap_q + (CNT_W+1)'(1);
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !done && !cap_valid && pin_nop));

    // R4
    trcd_gap_chk: assert property (@(posedge clk) disable iff (rst)
        pin_read |-> (gap_q == (CNT_W+1)'(T_RCD)));

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    cap_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        cap_valid |-> busy);

    // R11
    busy_no_act_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && req_valid) |=> !pin_act);
endmodule

// File: tb/ddr_burst_reader_test.sv
`timescale 1ns/1ps
module ddr_burst_reader_test;
    localparam int T_RCD = 3;
    localparam int CL    = 3;
    localparam int NWIN  = T_RCD + CL + 14;

    typedef struct packed {
        logic [1:0]  bank;
        logic [11:0] row;
        logic [7:0]  col;
        logic        ilv;
        logic [1:0]  blen;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd1, 12'h123, 8'h05, 1'b0, 2'b10},
        '{2'd2, 12'hABC, 8'h05, 1'b1, 2'b10},
        '{2'd3, 12'h7FF, 8'h17, 1'b0, 2'b11},
        '{2'd0, 12'h001, 8'h17, 1'b1, 2'b11},
        '{2'd1, 12'h3C3, 8'hFE, 1'b0, 2'b01},
        '{2'd2, 12'h555, 8'h03, 1'b1, 2'b01},
        '{2'd0, 12'hFFF, 8'h00, 1'b0, 2'b00},
        '{2'd3, 12'h800, 8'hFF, 1'b0, 2'b11}
    };

    logic        clk = 0;
    logic        rst = 1;
    logic        req_valid = 0;
    logic [1:0]  req_bank = '0;
    logic [11:0] req_row = '0;
    logic [7:0]  req_col = '0;
    logic        cfg_interleave = 0;
    logic [1:0]  cfg_blen = '0;
    logic        cs_n, ras_n, cas_n, we_n;
    logic [1:0]  ba;
    logic [11:0] addr;
    logic [15:0] dq;
    logic        dqs;
    logic        busy, done, cap_valid;
    logic [15:0] cap_data0, cap_data1;
    logic [7:0]  cap_col0, cap_col1;

    int tests = 0;
    int fails = 0;

    // mode programmed into the responder for the current burst
    logic        resp_ilv = 0;
    int          resp_bl  = 2;

    always #10 clk = ~clk;

    ddr_burst_reader #(
        .BA_W(2), .ROW_W(12), .COL_W(8), .DQ_W(16), .T_RCD(T_RCD), .CAS_LAT(CL)
    ) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_bank(req_bank),
        .req_row(req_row), .req_col(req_col), .cfg_interleave(cfg_interleave),
        .cfg_blen(cfg_blen), .sdram_cs_n(cs_n), .sdram_ras_n(ras_n),
        .sdram_cas_n(cas_n), .sdram_we_n(we_n), .sdram_ba(ba), .sdram_addr(addr),
        .dq(dq), .dqs(dqs), .busy(busy), .done(done), .cap_valid(cap_valid),
        .cap_data0(cap_data0), .cap_data1(cap_data1),
        .cap_col0(cap_col0), .cap_col1(cap_col1)
    );

    function automatic int len_of(input logic [1:0] code);
        if (code == 2'b11) return 8;
        if (code == 2'b10) return 4;
        return 2;
    endfunction

    function automatic logic [7:0] exp_col(input logic [7:0] s, input int i,
                                           input logic ilv, input int bl);
        int base, off, w;
        base = int'(s) - (int'(s) % bl);
        off  = int'(s) % bl;
        w    = ilv ? (off ^ i) : ((off + i) % bl);
        return 8'(base + w);
    endfunction

    function automatic logic [15:0] mem_word(input logic [1:0] b, input logic [11:0] r,
                                             input logic [7:0] c);
        return {c, r[3:0], 2'b00, b};
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // behavioural memory: opens rows, answers reads on both strobe edges
    logic [11:0] open_row;
    initial begin
        dqs = 0;
        dq  = '0;
        open_row = '0;
        forever begin
            @(negedge clk);
            if (!rst && !cs_n && !ras_n && cas_n && we_n) open_row = addr;
            if (!rst && !cs_n && ras_n && !cas_n && we_n) begin
                logic [1:0] rb;
                logic [7:0] rc;
                rb = ba;
                rc = addr[7:0];
                repeat (CL + 1) @(posedge clk);
                for (int k = 0; k < resp_bl / 2; k++) begin
                    dq = mem_word(rb, open_row, exp_col(rc, 2 * k, resp_ilv, resp_bl));
                    #5 dqs = 1;
                    #5 dq = mem_word(rb, open_row, exp_col(rc, 2 * k + 1, resp_ilv, resp_bl));
                    #5 dqs = 0;
                    #5;
                end
            end
        end
    end

    task automatic run_read(input vec_t v, input bit spam);
        int bl, npair, t_read, t_first, t_done;
        int acts, reads, pairs, dones, others;
        bit done_seen;
        bl = len_of(v.blen);
        npair = bl / 2;
        t_read = 1 + T_RCD;
        t_first = t_read + CL + 2;
        t_done = t_first + npair;
        acts = 0; reads = 0; pairs = 0; dones = 0; others = 0;
        done_seen = 0;
        resp_ilv = v.ilv;
        resp_bl  = bl;
        @(negedge clk);
        req_bank = v.bank; req_row = v.row; req_col = v.col;
        cfg_interleave = v.ilv; cfg_blen = v.blen; req_valid = 1;
        for (int t = 1; t <= NWIN; t++) begin
            @(negedge clk);
            if (t == 1) req_valid = 0;
            if (spam && t == 3) begin
                req_bank = ~v.bank; req_row = ~v.row; req_col = ~v.col;
                cfg_interleave = ~v.ilv; cfg_blen = (v.blen == 2'b11) ? 2'b01 : 2'b11;
                req_valid = 1;
            end
            if (!cs_n && !ras_n && cas_n && we_n) begin
                acts++;
                chk(t == 1, "R3", "activate cycle", t, 1);
                chk(ba == v.bank && addr == v.row, "R3", "activate row", int'(addr), int'(v.row));
            end else if (!cs_n && ras_n && !cas_n && we_n) begin
                reads++;
                chk(t == t_read, "R4", "read cycle", t, t_read);
                chk(ba == v.bank && addr == {4'b0, v.col}, "R4", "read column",
                    int'(addr), int'(v.col));
            end else if (!(!cs_n && ras_n && cas_n && we_n)) begin
                others++;
            end
            if (cap_valid) begin
                logic [7:0] e0, e1;
                e0 = exp_col(v.col, 2 * pairs, v.ilv, bl);
                e1 = exp_col(v.col, 2 * pairs + 1, v.ilv, bl);
                chk(t == t_first + pairs, "R6", "pair cycle", t, t_first + pairs);
                chk(cap_col0 == e0 && cap_col1 == e1, v.ilv ? "R9" : "R8", "pair columns",
                    int'({cap_col0, cap_col1}), int'({e0, e1}));
                chk(cap_data0 == mem_word(v.bank, v.row, e0), "R7", "rising word",
                    int'(cap_data0), int'(mem_word(v.bank, v.row, e0)));
                chk(cap_data1 == mem_word(v.bank, v.row, e1), "R7", "falling word",
                    int'(cap_data1), int'(mem_word(v.bank, v.row, e1)));
                pairs++;
            end
            if (t == t_done - 1) chk(busy == 1'b1, "R10", "busy before done", int'(busy), 1);
            if (done) begin
                dones++;
                chk(t == t_done, "R10", "done cycle", t, t_done);
                chk(!busy, "R10", "busy with done", int'(busy), 0);
                done_seen = 1;
            end
            if (spam && done_seen) req_valid = 0;
        end
        chk(acts == 1, spam ? "R11" : "R3", "activate count", acts, 1);
        chk(reads == 1, "R4", "read count", reads, 1);
        chk(pairs == npair, spam ? "R12" : "R5", "pair count", pairs, npair);
        chk(dones == 1, "R10", "done count", dones, 1);
        chk(others == 0, "R2", "non-nop idle cycles", others, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state held during reset
        chk(!busy && !done && !cap_valid, "R1", "outputs in reset",
            int'({busy, done, cap_valid}), 0);
        chk(!cs_n && ras_n && cas_n && we_n, "R1", "pins in reset",
            int'({cs_n, ras_n, cas_n, we_n}), 4'b0111);
        rst = 0;
        repeat (3) @(negedge clk);
        // R2: idle cycles carry the no-operation code
        chk(!cs_n && ras_n && cas_n && we_n && !busy, "R2", "idle pins",
            int'({cs_n, ras_n, cas_n, we_n}), 4'b0111);

        for (int i = 0; i < 8; i++) begin
            run_read(VECS[i], 1'b0);
            repeat (2) @(negedge clk);
        end

        // R11 / R12: request held high while busy with different settings
        run_read(VECS[2], 1'b1);
        repeat (4) @(negedge clk);

        // R1: reset in the middle of a burst
        resp_ilv = VECS[0].ilv;
        resp_bl  = len_of(VECS[0].blen);
        req_bank = VECS[0].bank; req_row = VECS[0].row; req_col = VECS[0].col;
        cfg_interleave = VECS[0].ilv; cfg_blen = VECS[0].blen; req_valid = 1;
        for (int t = 1; t <= 1 + T_RCD + CL + 2; t++) begin
            @(negedge clk);
            if (t == 1) req_valid = 0;
        end
        chk(cap_valid == 1'b1, "R6", "first pair before reset", int'(cap_valid), 1);
        rst = 1;
        @(negedge clk);
        chk(!busy && !done && !cap_valid, "R1", "outputs after mid-burst reset",
            int'({busy, done, cap_valid}), 0);
        chk(!cs_n && ras_n && cas_n && we_n, "R1", "pins after mid-burst reset",
            int'({cs_n, ras_n, cas_n, we_n}), 4'b0111);
        rst = 0;
        begin
            int stray;
            stray = 0;
            for (int t = 0; t < 12; t++) begin
                @(negedge clk);
                if (cap_valid || busy || done) stray++;
            end
            chk(stray == 0, "R1", "activity after reset", stray, 0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule